// File: doc/BRIEF.md
# Instruction Cycle Timing Sequencer

This block is the hardwired sequencing core of a 16-bit accumulator processor with a 4096-word address space. A 4-bit step counter advances once per clock. It is decoded into sixteen one-hot timing lines, and the three opcode bits of the instruction register are decoded into eight one-hot operation lines. From these lines the block steps each instruction through three phases: address fetch, instruction read and decode, then an optional indirect-address step. After that it hands control to an execute phase that lies outside the block. The block holds the address register, the program counter, the instruction register and the indirect flag. It emits their load and increment strobes, a memory read strobe, and the 3-bit select code of the shared 16-bit bus.

Memory is an external combinational read port addressed by the address register. The execute logic of individual memory-reference instructions is also outside the block. It ends such an instruction by pulsing `exec_done`. Register-reference and I/O instructions end themselves after their single execute step. A pending interrupt (`int_pending`) masks the fetch and decode strobes. A `start` pulse restarts the counter and loads the program counter with a chosen address.

The named phases, derived each cycle from the timing and operation lines, are:
- FETCH_ADDR: T0.
- FETCH_READ: T1.
- DECODE: T2.
- INDIRECT: T3 with opcode not 7 and I=1.
- DIRECT_WAIT: T3 with opcode not 7 and I=0.
- REG_EXEC: T3 with opcode 7 and I=0.
- IO_EXEC: T3 with opcode 7 and I=1.
- MEM_EXEC: T4 to T15.
- INT_HOLD: T0 to T2 while an interrupt is pending.

The transitions are:
- The step counter advances by one on every clock.
- It wraps from 15 to 0.
- It returns to 0 (FETCH_ADDR) after REG_EXEC, after IO_EXEC, on `exec_done`, and on `start`.

Top module: `instr_cycle_seq`

## Requirements
- R1: While reset is held, the step counter is 0, so only `t_sig[0]` is high. `ar_q`, `pc_q`, `ir_q` and `ind_flag` are all 0.
- R2: `t_sig` is one-hot, with bit k high when the step counter holds k. With no clear condition, the counter goes from k to k+1 on each clock, and from 15 to 0.
- R3: At T0 with `int_pending` low, the block drives select code 010 and `ar_ld`. `bus_q` carries `{4'b0, pc_q}`. After the edge, `ar_q` equals the old `pc_q`.
- R4: At T1 with `int_pending` low, the block drives select code 111, `mem_rd`, `ir_ld` and `pc_inr`. `bus_q` carries `mem_rdata`. After the edge, `ir_q` holds the memory word and `pc_q` holds the old value plus 1, taken modulo 4096.
- R5: At T2 with `int_pending` low, the block drives select code 101 (the bus carries `ir_q`) and `ar_ld`. After the edge, `ar_q = ir_q[11:0]` and `ind_flag = ir_q[15]`. `d_sig` is always one-hot, with bit `ir_q[14:12]` high.
- R6: At T3 with `ir_q[14:12]` not 7 and `ind_flag` high, the block drives `mem_rd`, `ar_ld` and select code 111. After the edge, `ar_q` holds the low 12 bits of the memory word.
- R7: At T3 with `ir_q[14:12]` not 7 and `ind_flag` low, `ar_ld`, `mem_rd`, `ir_ld` and `pc_inr` stay low. `ar_q` is unchanged and the counter moves to T4.
- R8: At T3 with `ir_q[14:12]` equal to 7, `sc_clr` is high whatever the value of `ind_flag`, and the next step is T0.
- R9: When `exec_done` is high at a clock edge, the next step is T0.
- R10: While `int_pending` is high at T0, T1 or T2, `ar_ld`, `mem_rd`, `ir_ld` and `pc_inr` stay low, and `ar_q`, `pc_q`, `ir_q` and `ind_flag` keep their values.
- R11: When `start` is high at a clock edge, the next step is T0 and `pc_q` takes `start_addr`. This overrides the increment at T1.
- R12: When no source is selected (select code 000, for example at T4 and later), `bus_q` is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Restart: clear the counter, load the PC |
| start_addr | input | 12 | Address loaded into the PC on `start` |
| int_pending | input | 1 | Interrupt pending; masks the fetch and decode strobes |
| exec_done | input | 1 | End of a memory-reference execute; clears the counter |
| mem_rdata | input | 16 | Combinational memory word at `ar_q` |
| t_sig | output | 16 | One-hot timing lines T0..T15 |
| d_sig | output | 8 | One-hot opcode lines D0..D7 |
| ind_flag | output | 1 | Indirect flag I |
| ar_q | output | 12 | Address register (memory address) |
| pc_q | output | 12 | Program counter |
| ir_q | output | 16 | Instruction register |
| bus_q | output | 16 | Value on the shared bus |
| bus_sel | output | 3 | Bus source code: 000 none, 001 AR, 010 PC, 101 IR, 111 memory |
| ar_ld | output | 1 | AR load strobe |
| pc_inr | output | 1 | PC increment strobe |
| pc_ld | output | 1 | PC load strobe (start) |
| ir_ld | output | 1 | IR load strobe |
| mem_rd | output | 1 | Memory read strobe |
| sc_clr | output | 1 | Step counter clear strobe |

## Verification
The strobes, the bus select code and `bus_q` depend only on the current step. They are due in the same cycle as the step, so the bench samples them at the falling edge inside that step. Register results (`ar_q`, `pc_q`, `ir_q`, `ind_flag`) are due one rising edge after the step that drives their strobe, and a counter clear shows up as T0 one edge after the clear condition. The bench therefore advances exactly one edge before it checks each of these. All inputs change at falling edges, half a period away from the rising edge at which the design samples them.

// File: rtl/seq_pkg.sv
package seq_pkg;

    // Source codes for the shared bus; the encodings are observed outside the block.
    typedef enum logic [2:0] {
        BUS_NONE = 3'b000,
        BUS_AR   = 3'b001,
        BUS_PC   = 3'b010,
        BUS_IR   = 3'b101,
        BUS_MEM  = 3'b111
    } bus_src_e;

    // Named phases of one instruction cycle.
    typedef enum logic [3:0] {
        PH_FETCH_ADDR,
        PH_FETCH_READ,
        PH_DECODE,
        PH_INDIRECT,
        PH_DIRECT_WAIT,
        PH_REG_EXEC,
        PH_IO_EXEC,
        PH_MEM_EXEC,
        PH_INT_HOLD
    } phase_e;

endpackage

// File: rtl/seq_timing.sv
module seq_timing #(
    parameter int SCW = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    output logic [(1<<SCW)-1:0]  t_out
);
    localparam int NT = 1 << SCW;

    logic [SCW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    for (genvar k = 0; k < NT; k++) begin : g_tdec
        assign t_out[k] = (cnt == SCW'(k));
    end
endmodule

// File: rtl/op_decoder.sv
module op_decoder #(
    parameter int OPW = 3
) (
    input  logic [OPW-1:0]      code,
    output logic [(1<<OPW)-1:0] dec
);
    localparam int ND = 1 << OPW;

    for (genvar k = 0; k < ND; k++) begin : g_odec
        assign dec[k] = (code == OPW'(k));
    end
endmodule

// File: rtl/bus_mux.sv
module bus_mux
    import seq_pkg::*;
#(
    parameter int AW = 12,
    parameter int DW = 16
) (
    input  bus_src_e        sel,
    input  logic [AW-1:0]   ar,
    input  logic [AW-1:0]   pc,
    input  logic [DW-1:0]   ir,
    input  logic [DW-1:0]   mem,
    output logic [DW-1:0]   bus
);
    localparam int PADW = DW - AW;

    always_comb begin
        unique case (sel)
            BUS_AR:  bus = {{PADW{1'b0}}, ar};
            BUS_PC:  bus = {{PADW{1'b0}}, pc};
            BUS_IR:  bus = ir;
            BUS_MEM: bus = mem;
            default: bus = '0;
        endcase
    end
endmodule

// File: rtl/instr_cycle_seq.sv
module instr_cycle_seq
    import seq_pkg::*;
#(
    parameter int AW  = 12,
    parameter int DW  = 16,
    parameter int SCW = 4,
    parameter int OPW = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [AW-1:0]        start_addr,
    input  logic                 int_pending,
    input  logic                 exec_done,
    input  logic [DW-1:0]        mem_rdata,
    output logic [(1<<SCW)-1:0]  t_sig,
    output logic [(1<<OPW)-1:0]  d_sig,
    output logic                 ind_flag,
    output logic [AW-1:0]        ar_q,
    output logic [AW-1:0]        pc_q,
    output logic [DW-1:0]        ir_q,
    output logic [DW-1:0]        bus_q,
    output logic [2:0]           bus_sel,
    output logic                 ar_ld,
    output logic                 pc_inr,
    output logic                 pc_ld,
    output logic                 ir_ld,
    output logic                 mem_rd,
    output logic                 sc_clr
);
    localparam int ND     = 1 << OPW;
    localparam int OP_LSB = DW - 1 - OPW;

    phase_e   phase;
    bus_src_e src;
    logic     i_ld;
    logic     step_clr;
    logic     fetch_win;

    // Timing lines from the clearable step counter.
    seq_timing #(.SCW(SCW)) u_timing (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (sc_clr),
        .t_out (t_sig)
    );

    // Opcode field decode.
    op_decoder #(.OPW(OPW)) u_opdec (
        .code (ir_q[DW-2:OP_LSB]),
        .dec  (d_sig)
    );

    bus_mux #(.AW(AW), .DW(DW)) u_bus (
        .sel (src),
        .ar  (ar_q),
        .pc  (pc_q),
        .ir  (ir_q),
        .mem (mem_rdata),
        .bus (bus_q)
    );

    assign fetch_win = t_sig[0] | t_sig[1] | t_sig[2];

    // Phase classification from timing and opcode lines.
    always_comb begin
        if (int_pending && fetch_win) begin
            phase = PH_INT_HOLD;
        end else if (t_sig[0]) begin
            phase = PH_FETCH_ADDR;
        end else if (t_sig[1]) begin
            phase = PH_FETCH_READ;
        end else if (t_sig[2]) begin
            phase = PH_DECODE;
        end else if (t_sig[3]) begin
            if (d_sig[ND-1]) begin
                phase = ind_flag ? PH_IO_EXEC : PH_REG_EXEC;
            end else begin
                phase = ind_flag ? PH_INDIRECT : PH_DIRECT_WAIT;
            end
        end else begin
            phase = PH_MEM_EXEC;
        end
    end

    // Strobes and bus source per phase.
    always_comb begin
        src      = BUS_NONE;
        ar_ld    = 1'b0;
        pc_inr   = 1'b0;
        ir_ld    = 1'b0;
        mem_rd   = 1'b0;
        i_ld     = 1'b0;
        step_clr = 1'b0;
        unique case (phase)
            PH_FETCH_ADDR: begin
                src   = BUS_PC;
                ar_ld = 1'b1;
            end
            PH_FETCH_READ: begin
                src    = BUS_MEM;
                mem_rd = 1'b1;
                ir_ld  = 1'b1;
                pc_inr = 1'b1;
            end
            PH_DECODE: begin
                src   = BUS_IR;
                ar_ld = 1'b1;
                i_ld  = 1'b1;
            end
            PH_INDIRECT: begin
                src    = BUS_MEM;
                mem_rd = 1'b1;
                ar_ld  = 1'b1;
            end
            PH_REG_EXEC, PH_IO_EXEC: begin
                step_clr = 1'b1;
            end
            PH_DIRECT_WAIT, PH_MEM_EXEC, PH_INT_HOLD: begin
                src = BUS_NONE;
            end
            default: begin
                src = BUS_NONE;
            end
        endcase
    end

    assign bus_sel = src;
    assign pc_ld   = start;
    assign sc_clr  = start | exec_done | step_clr;

    // Architectural registers; the 12-bit ones take the low bus bits.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ar_q     <= '0;
            pc_q     <= '0;
            ir_q     <= '0;
            ind_flag <= 1'b0;
        end else begin
            if (ar_ld) begin
                ar_q <= bus_q[AW-1:0];
            end
            if (pc_ld) begin
                pc_q <= start_addr;
            end else if (pc_inr) begin
                pc_q <= pc_q + 1'b1;
            end
            if (ir_ld) begin
                ir_q <= bus_q;
            end
            if (i_ld) begin
                ind_flag <= ir_q[DW-1];
            end
        end
    end
endmodule

// File: rtl/instr_cycle_seq_chk.sv
module instr_cycle_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic [11:0] start_addr,
    input logic        int_pending,
    input logic        exec_done,
    input logic [15:0] t_sig,
    input logic [7:0]  d_sig,
    input logic [11:0] ar_q,
    input logic [11:0] pc_q,
    input logic [15:0] bus_q,
    input logic [2:0]  bus_sel,
    input logic        ar_ld,
    input logic        pc_inr,
    input logic        ir_ld,
    input logic        mem_rd
);
    assert_step_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !exec_done && !(t_sig[3] && d_sig[7]) && !t_sig[15])
        |=> (t_sig == ($past(t_sig) << 1)));

    assert_pc_to_ar_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (t_sig[0] && !int_pending) |=> (ar_q == $past(pc_q)));

    assert_pc_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (t_sig[1] && !int_pending && !start) |=> (pc_q == $past(pc_q) + 12'd1));

    assert_op_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(d_sig) == 1);

    assert_short_exec_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (t_sig[3] && d_sig[7]) |=> t_sig[0]);

    assert_done_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        exec_done |=> t_sig[0]);

    assert_int_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (int_pending && (t_sig[0] || t_sig[1] || t_sig[2]))
        |-> !(ar_ld || ir_ld || mem_rd || pc_inr));

    assert_start_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (t_sig[0] && (pc_q == $past(start_addr))));

    assert_idle_bus_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel == 3'b000) |-> (bus_q == 16'h0000));
endmodule

bind instr_cycle_seq instr_cycle_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .start_addr  (start_addr),
    .int_pending (int_pending),
    .exec_done   (exec_done),
    .t_sig       (t_sig),
    .d_sig       (d_sig),
    .ar_q        (ar_q),
    .pc_q        (pc_q),
    .bus_q       (bus_q),
    .bus_sel     (bus_sel),
    .ar_ld       (ar_ld),
    .pc_inr      (pc_inr),
    .ir_ld       (ir_ld),
    .mem_rd      (mem_rd)
);

// File: tb/instr_cycle_seq_tb_top.sv
`timescale 1ns/1ps
module instr_cycle_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [11:0] start_addr;
    logic        int_pending;
    logic        exec_done;
    logic [15:0] mem_rdata;
    logic [15:0] t_sig;
    logic [7:0]  d_sig;
    logic        ind_flag;
    logic [11:0] ar_q;
    logic [11:0] pc_q;
    logic [15:0] ir_q;
    logic [15:0] bus_q;
    logic [2:0]  bus_sel;
    logic        ar_ld, pc_inr, pc_ld, ir_ld, mem_rd, sc_clr;

    int nvec = 0;
    int nerr = 0;

    logic [15:0] mem [0:63];
    assign mem_rdata = mem[ar_q[5:0]];

    always #2.5 clk = ~clk;

    instr_cycle_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .int_pending(int_pending), .exec_done(exec_done), .mem_rdata(mem_rdata),
        .t_sig(t_sig), .d_sig(d_sig), .ind_flag(ind_flag), .ar_q(ar_q),
        .pc_q(pc_q), .ir_q(ir_q), .bus_q(bus_q), .bus_sel(bus_sel),
        .ar_ld(ar_ld), .pc_inr(pc_inr), .pc_ld(pc_ld), .ir_ld(ir_ld),
        .mem_rd(mem_rd), .sc_clr(sc_clr)
    );

    // {start address, instruction word, pointer word, step at which execute ends}
    localparam logic [47:0] VECS [0:5] = '{
        {12'h010, 16'h1025, 16'h0000, 4'd5},
        {12'h020, 16'h9A33, 16'hF07C, 4'd6},
        {12'h030, 16'h7800, 16'h0000, 4'd0},
        {12'hFFF, 16'hF400, 16'h0000, 4'd0},
        {12'h005, 16'hE7A0, 16'h1234, 4'd4},
        {12'h03A, 16'h0008, 16'h0000, 4'd15}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nerr++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        logic [11:0] sa, pn, ar_keep, pc_keep;
        logic [15:0] ins, ptr, ir_keep;
        logic [3:0]  dn;
        logic [2:0]  op;
        logic        ind, i_keep;

        for (int k = 0; k < 64; k++) mem[k] = 16'h0000;
        rst_n = 1'b0; start = 1'b0; start_addr = '0;
        int_pending = 1'b0; exec_done = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 t_sig", t_sig, 32'h1);
        chk("R1 regs", {ar_q, pc_q, ir_q, 3'b0, ind_flag}, 32'h0);
        chk("R1 ir", ir_q, 32'h0);
        rst_n = 1'b1;

        for (int v = 0; v < 6; v++) begin
            sa  = VECS[v][47:36];
            ins = VECS[v][35:20];
            ptr = VECS[v][19:4];
            dn  = VECS[v][3:0];
            op  = ins[14:12];
            ind = ins[15];
            pn  = sa + 12'd1;
            mem[sa[5:0]]  = ins;
            mem[ins[5:0]] = ptr;
            start = 1'b1; start_addr = sa;
            tick();
            start = 1'b0;
            chk("R11 pc load", pc_q, sa);
            chk("R2 T0", t_sig, 32'h1);
            chk("R3 sel", bus_sel, 32'h2);
            chk("R3 bus", bus_q, {4'h0, sa});
            chk("R3 ar_ld", ar_ld, 32'h1);
            tick();
            chk("R3 ar", ar_q, sa);
            chk("R4 sel", bus_sel, 32'h7);
            chk("R4 strobes", {mem_rd, ir_ld, pc_inr}, 32'h7);
            chk("R4 bus", bus_q, ins);
            tick();
            chk("R4 ir", ir_q, ins);
            chk("R4 pc", pc_q, pn);
            chk("R5 d_sig", d_sig, 32'h1 << op);
            chk("R5 sel", bus_sel, 32'h5);
            tick();
            chk("R5 ar", ar_q, ins[11:0]);
            chk("R5 ind", ind_flag, ind);
            chk("R2 T3", t_sig, 32'h8);
            if (op == 3'd7) begin
                chk("R8 sc_clr", sc_clr, 32'h1);
                tick();
                chk("R8 T0", t_sig, 32'h1);
            end else if (ind) begin
                chk("R6 strobes", {ar_ld, mem_rd, bus_sel}, 32'h1F);
                tick();
                chk("R6 ar", ar_q, ptr[11:0]);
            end else begin
                chk("R7 quiet", {ar_ld, mem_rd, pc_inr, ir_ld}, 32'h0);
                tick();
                chk("R7 ar", ar_q, ins[11:0]);
            end
            if (op != 3'd7) begin
                chk("R2 T4", t_sig, 32'h10);
                chk("R12 idle bus", {bus_sel, bus_q}, 32'h0);
                for (int s = 4; s < dn; s++) tick();
                chk("R2 step", t_sig, 32'h1 << dn);
                exec_done = 1'b1;
                tick();
                exec_done = 1'b0;
                chk("R9 T0", t_sig, 32'h1);
            end
        end

        // R10: interrupt pending masks fetch and decode
        int_pending = 1'b1;
        start = 1'b1; start_addr = 12'h040;
        tick();
        start = 1'b0;
        ar_keep = ar_q; pc_keep = pc_q; ir_keep = ir_q; i_keep = ind_flag;
        chk("R10 T0 strobes", {ar_ld, mem_rd, ir_ld, pc_inr, bus_sel}, 32'h0);
        tick();
        chk("R10 T1 strobes", {ar_ld, mem_rd, ir_ld, pc_inr}, 32'h0);
        chk("R10 ar kept", ar_q, ar_keep);
        tick();
        chk("R10 pc kept", pc_q, pc_keep);
        chk("R10 ir kept", ir_q, ir_keep);
        chk("R10 T2 strobes", {ar_ld, mem_rd, ir_ld, pc_inr}, 32'h0);
        tick();
        chk("R10 i kept", ind_flag, i_keep);
        chk("R10 ar kept T3", ar_q, ar_keep);
        int_pending = 1'b0;
        exec_done = 1'b1;
        tick();
        exec_done = 1'b0;
        chk("R9 T0 after hold", t_sig, 32'h1);

        // R11: start during T1 wins over the increment
        tick();
        start = 1'b1; start_addr = 12'h123;
        tick();
        start = 1'b0;
        chk("R11 start over inc", pc_q, 32'h123);
        chk("R11 T0", t_sig, 32'h1);

        // R2: free run wraps from T15 to T0 (direct memory reference)
        mem[6'h23] = 16'h0011;
        repeat (3) tick();
        for (int s = 3; s < 15; s++) tick();
        chk("R2 T15", t_sig, 32'h8000);
        tick();
        chk("R2 wrap", t_sig, 32'h1);

        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule